// File: doc/BRIEF.md
# Cascaded Two-Stage Interrupt Controller

The block gathers sixteen edge-triggered interrupt lines into a single interrupt request for a processor. Two identical priority stages are chained: the primary stage serves lines 0 to 7 and the secondary stage serves lines 8 to 15. The secondary stage's request is fed into primary input 2, so input 2 of `irq_in` has no function.

Software reaches the block through an 8-bit I/O port bus with four addresses. Each stage has one address for its mask register and one for commands. A command write either closes the current service with an end-of-interrupt or sets the stage's vector base. When the processor acknowledges, the block returns an 8-bit vector one cycle later. That vector is the winning stage's base plus the line index.

Priority is fixed: the lowest line index is the most urgent. All secondary requests rank at the level of primary input 2. An in-service register in each stage keeps a line, and every line of lower priority, from interrupting until software ends that service.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset, both mask registers read FFh, which disables every line. `int_req` is 0 and `int_vector` is 00h. The primary base is 08h and the secondary base is 70h.
- R2: A write to a mask port (primary 21h, secondary A1h) is returned unchanged by a read of the same port while `io_rd` is high. Reads of any other address return 00h.
- R3: A line whose mask bit is 1 does not assert `int_req`. Its rising edge is still latched, and clearing the mask bit later delivers it.
- R4: A request is latched only on a rising input. A line that stays high after it has been serviced does not request again.
- R5: An acknowledge (`int_ack` high while `int_req` is high) loads `int_vector` on the next clock edge. The value is the stage base with the line index in bits 2:0. The request bit moves to the in-service register.
- R6: A command-port write (primary 20h, secondary A0h) with data bit 0 set loads that stage's base with data bits 7:3, and bits 2:0 become 0. For example, 21h selects base 20h.
- R7: When several unmasked lines are pending, the lowest-indexed line is acknowledged first.
- R8: A line cannot request while its own in-service bit, or any in-service bit of higher priority in its stage, is set. A higher-priority line can still interrupt.
- R9: Lines 8 to 15 reach `int_req` only when primary mask bit 2 is 0. They outrank primary lines 3 to 7. Their vector uses the secondary base, and acknowledging one also sets primary in-service bit 2.
- R10: Writing data 20h to a command port clears only the highest-priority in-service bit of that stage.
- R11: After a secondary line is serviced, an end-of-interrupt to the secondary stage alone leaves lines 2 to 15 blocked. Only the primary end-of-interrupt releases them.
- R12: `int_ack` while `int_req` is low has no effect, and `int_vector` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 16 | Interrupt lines; input 2 is unused because the cascade occupies it |
| io_addr | input | 8 | I/O port address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (combinational) |
| int_req | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | Interrupt acknowledge |
| int_vector | output | 8 | Vector of the last acknowledged interrupt |

## Verification
Several properties are checked on every cycle:
- an acknowledge sets the in-service bit of the line it selected;
- an end-of-interrupt removes exactly one in-service bit;
- a secondary acknowledge also marks primary input 2;
- the vector only changes on a real acknowledge;
- a fully masked primary stage never raises `int_req`;
- while input 2 is in service, only lines 0 and 1 can be acknowledged.

Other behaviour can only be shown by the bench's scenarios. These are the actual vector values, the base reprogramming, the latching of masked edges, the ordering of simultaneous requests, and the two-step end-of-interrupt release after a secondary service.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;

  localparam int LINES   = 8;
  localparam int IDX_W   = $clog2(LINES);
  localparam logic [7:0] EOI_CODE = 8'h20;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } pick_t;

  // Walk from the most urgent line; an in-service bit blocks itself and below.
  function automatic pick_t pick_line(input logic [LINES-1:0] pend,
                                      input logic [LINES-1:0] isr);
    pick_t  p;
    logic   blocked;
    p       = '0;
    blocked = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      if (isr[i]) blocked = 1'b1;
      if (!blocked && !p.hit && pend[i]) begin
        p.hit = 1'b1;
        p.idx = IDX_W'(i);
      end
    end
    return p;
  endfunction

  // One-hot of the most urgent in-service bit (zero when none).
  function automatic logic [LINES-1:0] top_service(input logic [LINES-1:0] isr);
    logic [LINES-1:0] oh;
    oh = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (isr[i]) oh = LINES'(1) << i;
    return oh;
  endfunction

  function automatic logic [7:0] make_vector(input logic [7:0] base,
                                             input logic [IDX_W-1:0] idx);
    return {base[7:IDX_W], idx};
  endfunction

endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lines,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lines;

  assign rise = lines & ~prev_q;
endmodule

// File: rtl/irq_stage.sv
module irq_stage
  import irq_cascade_pkg::*;
#(
  parameter logic [7:0]       RESET_BASE  = 8'h08,
  parameter logic [LINES-1:0] LEVEL_LINES = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lines,
  input  logic             mask_we,
  input  logic             cmd_we,
  input  logic [7:0]       wdata,
  input  logic             ack,
  output logic [LINES-1:0] mask_q,
  output logic [LINES-1:0] isr_q,
  output logic             req,
  output logic [IDX_W-1:0] win_idx,
  output logic [7:0]       vector,
  output logic             ack_fire,
  output logic             eoi_fire
);
  logic [LINES-1:0] rise, irr_q, irr_eff, pend, ack_oh, eoi_oh;
  logic [7:0]       base_q;
  logic             base_we;
  pick_t            pick;

  irq_edge_det #(.W(LINES)) u_edge (
    .clk(clk), .rst_n(rst_n), .lines(lines), .rise(rise)
  );

  // Level lines (the cascade input) bypass the edge latch.
  assign irr_eff  = (irr_q & ~LEVEL_LINES) | (lines & LEVEL_LINES);
  assign pend     = irr_eff & ~mask_q;
  assign pick     = pick_line(pend, isr_q);
  assign req      = pick.hit;
  assign win_idx  = pick.idx;
  assign vector   = make_vector(base_q, pick.idx);

  assign ack_fire = ack && pick.hit;
  assign eoi_fire = cmd_we && (wdata == EOI_CODE);
  assign base_we  = cmd_we && wdata[0];
  assign ack_oh   = ack_fire ? (LINES'(1) << pick.idx) : '0;
  assign eoi_oh   = eoi_fire ? top_service(isr_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      irr_q  <= '0;
      isr_q  <= '0;
      base_q <= RESET_BASE;
    end else begin
      irr_q <= ((irr_q & ~ack_oh) | rise) & ~LEVEL_LINES;
      isr_q <= (isr_q & ~eoi_oh) | ack_oh;
      if (mask_we) mask_q <= wdata;
      if (base_we) base_q <= {wdata[7:IDX_W], {IDX_W{1'b0}}};
    end
  end
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irq_cascade_pkg::*;
#(
  parameter logic [7:0] M_CMD_PORT  = 8'h20,
  parameter logic [7:0] M_MASK_PORT = 8'h21,
  parameter logic [7:0] S_CMD_PORT  = 8'hA0,
  parameter logic [7:0] S_MASK_PORT = 8'hA1,
  parameter logic [7:0] M_BASE_RST  = 8'h08,
  parameter logic [7:0] S_BASE_RST  = 8'h70,
  parameter int         CASCADE_IN  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] irq_in,
  input  logic [7:0]  io_addr,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  output logic        int_req,
  input  logic        int_ack,
  output logic [7:0]  int_vector
);
  localparam logic [LINES-1:0] CASC_OH = LINES'(1) << CASCADE_IN;

  logic [LINES-1:0] m_lines, m_mask, m_isr, s_mask, s_isr;
  logic [IDX_W-1:0] m_idx, s_idx;
  logic [7:0]       m_vector, s_vector;
  logic             m_req, s_req, m_ack_fire, s_ack_fire, m_eoi_fire, s_eoi_fire;
  logic             s_ack, unused_cascade_pin;
  logic [7:0]       vec_q;

  assign unused_cascade_pin = irq_in[CASCADE_IN];

  always_comb begin
    m_lines             = irq_in[7:0];
    m_lines[CASCADE_IN] = s_req;
  end

  irq_stage #(.RESET_BASE(M_BASE_RST), .LEVEL_LINES(CASC_OH)) u_primary (
    .clk(clk), .rst_n(rst_n), .lines(m_lines),
    .mask_we(io_wr && io_addr == M_MASK_PORT),
    .cmd_we (io_wr && io_addr == M_CMD_PORT),
    .wdata(io_wdata), .ack(int_ack),
    .mask_q(m_mask), .isr_q(m_isr), .req(m_req), .win_idx(m_idx),
    .vector(m_vector), .ack_fire(m_ack_fire), .eoi_fire(m_eoi_fire)
  );

  assign s_ack = m_ack_fire && (m_idx == IDX_W'(CASCADE_IN));

  irq_stage #(.RESET_BASE(S_BASE_RST), .LEVEL_LINES('0)) u_secondary (
    .clk(clk), .rst_n(rst_n), .lines(irq_in[15:8]),
    .mask_we(io_wr && io_addr == S_MASK_PORT),
    .cmd_we (io_wr && io_addr == S_CMD_PORT),
    .wdata(io_wdata), .ack(s_ack),
    .mask_q(s_mask), .isr_q(s_isr), .req(s_req), .win_idx(s_idx),
    .vector(s_vector), .ack_fire(s_ack_fire), .eoi_fire(s_eoi_fire)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          vec_q <= '0;
    else if (m_ack_fire) vec_q <= s_ack ? s_vector : m_vector;

  always_comb begin
    io_rdata = '0;
    if (io_rd && io_addr == M_MASK_PORT) io_rdata = m_mask;
    if (io_rd && io_addr == S_MASK_PORT) io_rdata = s_mask;
  end

  assign int_req    = m_req;
  assign int_vector = vec_q;
endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       int_ack,
  input logic       int_req,
  input logic [7:0] int_vector,
  input logic [7:0] m_mask,
  input logic [7:0] m_isr,
  input logic [2:0] m_idx,
  input logic       m_ack_fire,
  input logic       m_eoi_fire,
  input logic       s_ack_fire,
  input logic [2:0] s_idx,
  input logic [7:0] s_isr,
  input logic       s_eoi_fire
);
  // R5: the acknowledged line lands in service
  p_ack_marks_isr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    m_ack_fire |=> m_isr[$past(m_idx)]);

  // R5: the secondary acknowledge marks its own line too
  p_sec_ack_marks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    s_ack_fire |=> s_isr[$past(s_idx)]);

  // R10: an end-of-interrupt retires exactly one service
  p_eoi_drops_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_eoi_fire && !m_ack_fire && m_isr != 8'h00)
      |=> $countones(m_isr) == $countones($past(m_isr)) - 1);

  p_sec_eoi_drops_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (s_eoi_fire && !s_ack_fire && s_isr != 8'h00)
      |=> $countones(s_isr) == $countones($past(s_isr)) - 1);

  // R9: a secondary service always occupies primary input 2
  p_cascade_pairs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    s_ack_fire |=> m_isr[2]);

  // R12: vector moves only on a real acknowledge
  p_vector_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_ack || !int_req) |=> $stable(int_vector));

  // R3: nothing reaches the processor with the primary fully masked
  p_all_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_mask == 8'hFF) |-> !int_req);

  // R11: with input 2 in service only lines 0 and 1 can be taken
  p_cascade_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_isr[2] && m_ack_fire) |-> (m_idx < 3'd2));
endmodule

bind irq_cascade_ctrl irq_cascade_chk u_chk (
  .clk(clk), .rst_n(rst_n), .int_ack(int_ack), .int_req(int_req),
  .int_vector(int_vector), .m_mask(m_mask), .m_isr(m_isr), .m_idx(m_idx),
  .m_ack_fire(m_ack_fire), .m_eoi_fire(m_eoi_fire), .s_ack_fire(s_ack_fire),
  .s_idx(s_idx), .s_isr(s_isr), .s_eoi_fire(s_eoi_fire)
);

// File: tb/irq_cascade_ctrl_test.sv
module irq_cascade_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_in = '0;
  logic [7:0]  io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        int_req;
  logic        int_ack = 1'b0;
  logic [7:0]  int_vector;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  event       ack_done;

  always #10 clk = ~clk;  // 50 MHz

  irq_cascade_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .int_req(int_req), .int_ack(int_ack), .int_vector(int_vector)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic io_read_check(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    #1 check(tag, io_rdata, exp);
    io_rd = 1'b0;
  endtask

  task automatic set_irq(input logic [15:0] v);
    @(negedge clk); irq_in = v;
    @(negedge clk);
  endtask

  task automatic req_is(input logic exp, input string tag);
    #1 check(tag, {7'b0, int_req}, {7'b0, exp});
  endtask

  // Driver: queue the expected vector, then acknowledge.
  task automatic ack_expect(input logic [7:0] vec, input string tag);
    exp_q.push_back(vec);
    tag_q.push_back(tag);
    @(negedge clk); int_ack = 1'b1;
    @(negedge clk); int_ack = 1'b0;
    -> ack_done;
    #2;
  endtask

  // Monitor: compare each produced vector against the scoreboard.
  initial begin
    forever begin
      @(ack_done);
      #1;
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL scoreboard: actual %02h expected none", int_vector);
      end else begin
        check(tag_q.pop_front(), int_vector, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    req_is(1'b0, "R1 int_req after reset");
    check("R1 vector after reset", int_vector, 8'h00);
    io_read_check(8'h21, 8'hFF, "R1 primary mask reset");
    io_read_check(8'hA1, 8'hFF, "R1 secondary mask reset");
    // R2: read-modify-write of the mask
    io_write(8'h21, 8'hFE);
    io_read_check(8'h21, 8'hFE, "R2 primary mask readback");
    io_read_check(8'h20, 8'h00, "R2 non-mask address reads zero");
    // R12: stray acknowledge
    @(negedge clk); int_ack = 1'b1;
    @(negedge clk); int_ack = 1'b0;
    #1 check("R12 vector unchanged on stray ack", int_vector, 8'h00);
    // R5 and R4: basic service of line 0
    set_irq(16'h0001);
    req_is(1'b1, "R5 line 0 requests");
    ack_expect(8'h08, "R5 vector for line 0");
    req_is(1'b0, "R5 request cleared by ack");
    io_write(8'h20, 8'h20);
    req_is(1'b0, "R4 held-high line does not re-request");
    set_irq(16'h0000);
    // R3: masked edge kept and delivered later
    set_irq(16'h0002);
    req_is(1'b0, "R3 masked line quiet");
    io_write(8'h21, 8'hFC);
    req_is(1'b1, "R3 unmask delivers latched edge");
    ack_expect(8'h09, "R3 vector for line 1");
    io_write(8'h20, 8'h20);
    set_irq(16'h0000);
    // R7, R8, R10: priority and nesting
    io_write(8'h21, 8'hF0);
    set_irq(16'h000A);
    ack_expect(8'h09, "R7 lower index wins");
    req_is(1'b0, "R8 line 3 blocked by line 1 in service");
    set_irq(16'h000B);
    req_is(1'b1, "R8 line 0 may preempt");
    ack_expect(8'h08, "R8 vector of preempting line");
    io_write(8'h20, 8'h20);
    req_is(1'b0, "R10 first EOI clears only line 0");
    io_write(8'h20, 8'h20);
    req_is(1'b1, "R10 second EOI releases line 3");
    ack_expect(8'h0B, "R7 vector for line 3");
    io_write(8'h20, 8'h20);
    req_is(1'b0, "R10 all services closed");
    set_irq(16'h0000);
    // R6: base reprogramming
    io_write(8'h20, 8'h21);
    set_irq(16'h0002);
    ack_expect(8'h21, "R6 vector with new base");
    io_write(8'h20, 8'h20);
    set_irq(16'h0000);
    // R9, R11: cascade
    io_write(8'h21, 8'hF4);
    io_write(8'hA1, 8'hFE);
    set_irq(16'h0100);
    req_is(1'b0, "R9 secondary gated by primary mask bit 2");
    io_write(8'h21, 8'hF0);
    req_is(1'b1, "R9 secondary reaches processor");
    ack_expect(8'h70, "R9 secondary vector");
    io_write(8'hA0, 8'h20);
    io_write(8'hA1, 8'hFC);
    set_irq(16'h0308);
    req_is(1'b0, "R11 secondary EOI alone keeps cascade blocked");
    io_write(8'h20, 8'h20);
    req_is(1'b1, "R11 primary EOI releases");
    ack_expect(8'h71, "R9 secondary outranks line 3");
    io_write(8'hA0, 8'h20);
    io_write(8'h20, 8'h20);
    req_is(1'b1, "R9 line 3 follows");
    ack_expect(8'h23, "R6 line 3 vector with new base");
    io_write(8'h20, 8'h20);
    req_is(1'b0, "R10 idle at end");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule